// File: doc/BRIEF.md
# RTC Weekday-Masked Alarm Comparator

This block is the alarm unit of a real-time clock. Software programs an alarm minute, an alarm hour and a set of permitted weekdays into six 4-bit registers through a plain address/data port. The timekeeping counters elsewhere in the clock supply the running BCD minute, hour and weekday, plus a one-cycle tick when the seconds wrap to zero. On that tick the block compares the stored alarm against the running time. On a match it sets a sticky alarm flag and can pull an active-low interrupt line.

Hours are compared in one of two codings, chosen by a mode input. In 24-hour coding, bit D1 of the hour-tens register is the 20-hour digit. In 12-hour coding that bit marks PM, and the code 12 stands for hour zero, so AM midnight reads 12 and PM noon reads 32. Both the stored value and the running value are converted to a linear hour before the compare. A code that names no real time, such as minute 75 or hour 13 in 12-hour coding, never matches, even when the running input carries the same code.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, every register reads 0, `alarm_flag` is 0 and `irq_n` is 1, so the alarm is disabled and no weekday is permitted.
- R2: Register layout, with bit D3 first: address 0 holds weekday mask bits 3..0. Address 1 holds the interrupt-hold bit in D3 and weekday mask bits 6..4 in D2..D0. Address 2 holds the minute units. Address 3 holds the minute tens in D2..D0. Address 4 holds the hour units. Address 5 holds the enable bit in D3 and the hour tens in D1..D0, where D1 is PM (12-hour coding) or the 20-hour digit (24-hour coding). Each register reads back what was written, apart from the bits named in R3.
- R3: Bit D3 of address 3 and bit D2 of address 5 always read 0, and writes to them are ignored. Addresses 6 and 7 read 0 and ignore writes.
- R4: A match needs `min_tick` high, equal minute digits and equal hours. When it occurs, `alarm_flag` is 1 after that clock edge. Without `min_tick`, nothing is set.
- R5: While the enable bit (address 5, D3) is 0, no tick sets the flag.
- R6: Weekday input value n (0..6) may fire only if mask bit n is 1. Weekday value 7 never fires. An all-zero mask never fires.
- R7: In 12-hour coding (`mode_24h`=0), hour codes 01..12 are valid, 12 means hour zero, and D1 of the tens digit adds twelve hours. In 24-hour coding, codes 00..23 are valid. Invalid hour codes never match.
- R8: Minute codes with units above 9 or tens above 5 never match.
- R9: The flag is sticky. It is cleared by a `flag_clr` pulse, or by a write to address 1 with D3=1. A write to address 1 with D3=0 leaves it set.
- R10: `irq_n` is 0 exactly while the flag is 1 and the interrupt-hold bit is 0.
- R11: When a match falls in the same cycle as either clear request, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address (read and write) |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for `reg_addr`, combinational |
| min_tick | input | 1 | One-cycle pulse when the seconds wrap to zero |
| mode_24h | input | 1 | 1 selects 24-hour coding, 0 selects 12-hour coding |
| now_min_u | input | 4 | Running minute units, BCD |
| now_min_t | input | 3 | Running minute tens, BCD |
| now_hr_u | input | 4 | Running hour units, BCD |
| now_hr_t | input | 2 | Running hour tens; D1 is PM or the 20-hour digit |
| now_wday | input | 3 | Running weekday counter, 0..6 |
| flag_clr | input | 1 | One-cycle pulse that clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
A matching minute tick can land in the same cycle as a request to clear the flag. The request can come either from the `flag_clr` strobe or from a host write that sets the interrupt-hold bit. The bench drives `min_tick` high in the same cycle as each of these requests, with the running time equal to the alarm. It then expects the flag to be set one edge later. In the write case it also expects `irq_n` to stay high, because the same write sets the hold bit.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int unsigned ADR_DAYS_LO = 0;
   localparam int unsigned ADR_DAYS_HI = 1;
   localparam int unsigned ADR_MIN_U   = 2;
   localparam int unsigned ADR_MIN_T   = 3;
   localparam int unsigned ADR_HR_U    = 4;
   localparam int unsigned ADR_HR_T    = 5;
   localparam int unsigned NIB_W       = 4;
   localparam int unsigned HR_IDX_W    = 6;

   typedef struct packed {
      logic [6:0] day_mask;
      logic       hold;
      logic       enable;
      logic [3:0] min_u;
      logic [2:0] min_t;
      logic [3:0] hr_u;
      logic [1:0] hr_t;
   } alarm_cfg_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [NIB_W-1:0]    wdata_i,
   output logic [NIB_W-1:0]    rdata_o,
   output alarm_cfg_t          cfg_o,
   output logic                hold_wr_o
);
   alarm_cfg_t cfg_q;

   function automatic logic hit_adr(input logic [ADDR_W-1:0] a, input int unsigned n);
      return a == ADDR_W'(n);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_i) begin
         if (hit_adr(addr_i, ADR_DAYS_LO)) cfg_q.day_mask[3:0] <= wdata_i;
         if (hit_adr(addr_i, ADR_DAYS_HI)) begin
            cfg_q.hold           <= wdata_i[3];
            cfg_q.day_mask[6:4]  <= wdata_i[2:0];
         end
         if (hit_adr(addr_i, ADR_MIN_U)) cfg_q.min_u <= wdata_i;
         if (hit_adr(addr_i, ADR_MIN_T)) cfg_q.min_t <= wdata_i[2:0];
         if (hit_adr(addr_i, ADR_HR_U))  cfg_q.hr_u  <= wdata_i;
         if (hit_adr(addr_i, ADR_HR_T)) begin
            cfg_q.enable <= wdata_i[3];
            cfg_q.hr_t   <= wdata_i[1:0];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_adr(addr_i, ADR_DAYS_LO)) rdata_o = cfg_q.day_mask[3:0];
      if (hit_adr(addr_i, ADR_DAYS_HI)) rdata_o = {cfg_q.hold, cfg_q.day_mask[6:4]};
      if (hit_adr(addr_i, ADR_MIN_U))   rdata_o = cfg_q.min_u;
      if (hit_adr(addr_i, ADR_MIN_T))   rdata_o = {1'b0, cfg_q.min_t};
      if (hit_adr(addr_i, ADR_HR_U))    rdata_o = cfg_q.hr_u;
      if (hit_adr(addr_i, ADR_HR_T))    rdata_o = {cfg_q.enable, 1'b0, cfg_q.hr_t};
   end

   assign cfg_o     = cfg_q;
   assign hold_wr_o = wr_i && hit_adr(addr_i, ADR_DAYS_HI) && wdata_i[3];
endmodule

// File: rtl/rtc_alarm_hour_norm.sv
module rtc_alarm_hour_norm
   import rtc_alarm_pkg::*;
(
   input  logic [1:0]          tens_i,
   input  logic [3:0]          units_i,
   input  logic                mode_24h_i,
   output logic [HR_IDX_W-1:0] idx_o,
   output logic                valid_o
);
   logic [HR_IDX_W-1:0] low;
   logic [HR_IDX_W-1:0] full;
   logic                digit_ok;

   always_comb begin
      low      = (tens_i[0] ? HR_IDX_W'(10) : '0) + HR_IDX_W'(units_i);
      full     = low + (tens_i[1] ? HR_IDX_W'(20) : '0);
      digit_ok = units_i <= 4'd9;
      if (mode_24h_i) begin
         valid_o = digit_ok && (full <= HR_IDX_W'(23));
         idx_o   = full;
      end else begin
         valid_o = digit_ok && (low >= HR_IDX_W'(1)) && (low <= HR_IDX_W'(12));
         idx_o   = ((low == HR_IDX_W'(12)) ? '0 : low) + (tens_i[1] ? HR_IDX_W'(12) : '0);
      end
   end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned NUM_DAYS = 7,
   parameter int unsigned WDAY_W   = 3
) (
   input  alarm_cfg_t        cfg_i,
   input  logic              tick_i,
   input  logic              mode_24h_i,
   input  logic [3:0]        now_min_u_i,
   input  logic [2:0]        now_min_t_i,
   input  logic [3:0]        now_hr_u_i,
   input  logic [1:0]        now_hr_t_i,
   input  logic [WDAY_W-1:0] now_wday_i,
   output logic              hit_o
);
   logic [HR_IDX_W-1:0] al_idx, now_idx;
   logic                al_ok, now_ok;
   logic [NUM_DAYS-1:0] day_sel;
   logic                min_ok, hr_ok, day_ok;

   rtc_alarm_hour_norm u_al_hr (
      .tens_i(cfg_i.hr_t), .units_i(cfg_i.hr_u), .mode_24h_i(mode_24h_i),
      .idx_o(al_idx), .valid_o(al_ok));

   rtc_alarm_hour_norm u_now_hr (
      .tens_i(now_hr_t_i), .units_i(now_hr_u_i), .mode_24h_i(mode_24h_i),
      .idx_o(now_idx), .valid_o(now_ok));

   for (genvar d = 0; d < NUM_DAYS; d++) begin : g_day
      assign day_sel[d] = (now_wday_i == WDAY_W'(d));
   end

   assign min_ok = (cfg_i.min_u <= 4'd9) && (cfg_i.min_t <= 3'd5)
                && (cfg_i.min_u == now_min_u_i) && (cfg_i.min_t == now_min_t_i);
   assign hr_ok  = al_ok && now_ok && (al_idx == now_idx);
   assign day_ok = |(day_sel & cfg_i.day_mask[NUM_DAYS-1:0]);
   assign hit_o  = tick_i && cfg_i.enable && min_ok && hr_ok && day_ok;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned NUM_DAYS = 7,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [3:0]        reg_wdata,
   output logic [3:0]        reg_rdata,
   input  logic              min_tick,
   input  logic              mode_24h,
   input  logic [3:0]        now_min_u,
   input  logic [2:0]        now_min_t,
   input  logic [3:0]        now_hr_u,
   input  logic [1:0]        now_hr_t,
   input  logic [2:0]        now_wday,
   input  logic              flag_clr,
   output logic              alarm_flag,
   output logic              irq_n
);
   localparam int unsigned WDAY_W = 3;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("rtc_alarm_match: ADDR_W must reach address 5");
   end
   if (NUM_DAYS != 7) begin : g_bad_days
      $error("rtc_alarm_match: the mask layout holds exactly seven days");
   end

   alarm_cfg_t cfg_w;
   logic       hold_wr_w;
   logic       hit_w;
   logic       clr_w;
   logic       flag_q;
   logic       ale_w, alc_w;

   rtc_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .cfg_o(cfg_w),
      .hold_wr_o(hold_wr_w));

   rtc_alarm_cmp #(.NUM_DAYS(NUM_DAYS), .WDAY_W(WDAY_W)) u_cmp (
      .cfg_i(cfg_w), .tick_i(min_tick), .mode_24h_i(mode_24h),
      .now_min_u_i(now_min_u), .now_min_t_i(now_min_t),
      .now_hr_u_i(now_hr_u), .now_hr_t_i(now_hr_t),
      .now_wday_i(now_wday), .hit_o(hit_w));

   assign clr_w = flag_clr || hold_wr_w;

   if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     flag_q <= 1'b0;
         else if (hit_w) flag_q <= 1'b1;
         else if (clr_w) flag_q <= 1'b0;
      end
   end else begin : g_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     flag_q <= 1'b0;
         else if (clr_w) flag_q <= 1'b0;
         else if (hit_w) flag_q <= 1'b1;
      end
   end

   assign ale_w      = cfg_w.enable;
   assign alc_w      = cfg_w.hold;
   assign alarm_flag = flag_q;
   assign irq_n      = !(flag_q && !alc_w);
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              min_tick,
   input logic              flag_clr,
   input logic              alarm_flag,
   input logic              irq_n,
   input logic              ale,
   input logic              alc,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [3:0]        rd_data
);
   // R4
   flag_rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(min_tick));
   // R10
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (alarm_flag && !alc));
   // R10
   irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !alc) |-> !irq_n);
   // R9
   clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !min_tick) |=> !alarm_flag);
   // R5
   disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (min_tick && !ale && !alarm_flag) |=> !alarm_flag);
   // R3
   unused_min_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(3)) |-> !rd_data[3]);
   // R3
   unused_hr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(5)) |-> !rd_data[2]);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .flag_clr(flag_clr),
   .alarm_flag(alarm_flag), .irq_n(irq_n), .ale(ale_w), .alc(alc_w),
   .rd_addr(reg_addr), .rd_data(reg_rdata));

// File: tb/rtc_alarm_match_bench.sv
`timescale 1ns/1ps
module rtc_alarm_match_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       min_tick = 1'b0;
   logic       mode_24h = 1'b1;
   logic [3:0] now_min_u = '0;
   logic [2:0] now_min_t = '0;
   logic [3:0] now_hr_u = '0;
   logic [1:0] now_hr_t = '0;
   logic [2:0] now_wday = '0;
   logic       flag_clr = 1'b0;
   logic       alarm_flag;
   logic       irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int         kind;
      logic [3:0] exp;
      string      req;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   rtc_alarm_match u_rtc_alarm_match (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .min_tick(min_tick),
      .mode_24h(mode_24h), .now_min_u(now_min_u), .now_min_t(now_min_t),
      .now_hr_u(now_hr_u), .now_hr_t(now_hr_t), .now_wday(now_wday),
      .flag_clr(flag_clr), .alarm_flag(alarm_flag), .irq_n(irq_n));

   // Monitor: consumes every queued expectation at the falling edge.
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [3:0] act;
         it = sb.pop_front();
         act = (it.kind == 0) ? reg_rdata : {2'b00, alarm_flag, irq_n};
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: %s got %h expected %h", it.req,
                     (it.kind == 0) ? "rdata" : "{flag,irq_n}", act, it.exp);
         end
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask
   task automatic wr(input logic [2:0] a, input logic [3:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; step(); reg_wr = 1'b0;
   endtask
   task automatic rd(input logic [2:0] a, input logic [3:0] e, input string r);
      reg_addr = a; sb.push_back('{0, e, r}); step();
   endtask
   task automatic expect_out(input logic f, input logic i, input string r);
      sb.push_back('{1, {2'b00, f, i}, r}); step();
   endtask
   task automatic tick();
      min_tick = 1'b1; step(); min_tick = 1'b0;
   endtask
   task automatic clr();
      flag_clr = 1'b1; step(); flag_clr = 1'b0;
   endtask
   task automatic set_now(input logic [1:0] ht, input logic [3:0] hu,
                          input logic [2:0] mt, input logic [3:0] mu,
                          input logic [2:0] wd);
      now_hr_t = ht; now_hr_u = hu; now_min_t = mt; now_min_u = mu; now_wday = wd;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      for (int a = 0; a < 6; a++) rd(3'(a), 4'h0, "R1");
      expect_out(1'b0, 1'b1, "R1");

      // R2 layout and readback, R3 unused bits and addresses
      wr(3'd0, 4'hA); rd(3'd0, 4'hA, "R2");
      wr(3'd1, 4'h5); rd(3'd1, 4'h5, "R2");
      wr(3'd2, 4'h9); rd(3'd2, 4'h9, "R2");
      wr(3'd3, 4'hF); rd(3'd3, 4'h7, "R3");
      wr(3'd4, 4'h1); rd(3'd4, 4'h1, "R2");
      wr(3'd5, 4'hF); rd(3'd5, 4'hB, "R3");
      wr(3'd6, 4'hF); rd(3'd6, 4'h0, "R3");
      wr(3'd7, 4'hF); rd(3'd7, 4'h0, "R3");

      // Alarm 07:45 on weekday 2, 24-hour coding
      mode_24h = 1'b1;
      wr(3'd0, 4'h4); wr(3'd1, 4'h0); wr(3'd2, 4'h5);
      wr(3'd3, 4'h4); wr(3'd4, 4'h7); wr(3'd5, 4'h8);
      set_now(2'd0, 4'd7, 3'd4, 4'd5, 3'd2);
      step(); expect_out(1'b0, 1'b1, "R4 no tick");
      tick(); expect_out(1'b1, 1'b0, "R4 match");
      expect_out(1'b1, 1'b0, "R9 sticky");
      clr(); expect_out(1'b0, 1'b1, "R9 strobe clear");
      tick(); expect_out(1'b1, 1'b0, "R4 second match");
      wr(3'd1, 4'h8); expect_out(1'b0, 1'b1, "R9 hold write clear");
      tick(); expect_out(1'b1, 1'b1, "R10 held");
      wr(3'd1, 4'h0); expect_out(1'b1, 1'b0, "R9 R10 release keeps flag");
      clr(); expect_out(1'b0, 1'b1, "R9");

      // R6 weekday mask
      now_wday = 3'd3; tick(); expect_out(1'b0, 1'b1, "R6 wrong day");
      wr(3'd0, 4'hF); wr(3'd1, 4'h7);
      now_wday = 3'd7; tick(); expect_out(1'b0, 1'b1, "R6 day 7");
      now_wday = 3'd6; tick(); expect_out(1'b1, 1'b0, "R6 day 6");
      clr();
      wr(3'd0, 4'h0); wr(3'd1, 4'h0);
      now_wday = 3'd2; tick(); expect_out(1'b0, 1'b1, "R6 empty mask");
      wr(3'd0, 4'h4);

      // R4 digit mismatches
      set_now(2'd0, 4'd8, 3'd4, 4'd5, 3'd2); tick(); expect_out(1'b0, 1'b1, "R4 hour diff");
      set_now(2'd0, 4'd7, 3'd4, 4'd6, 3'd2); tick(); expect_out(1'b0, 1'b1, "R4 minute diff");
      set_now(2'd0, 4'd7, 3'd4, 4'd5, 3'd2);

      // R5 disabled
      wr(3'd5, 4'h0); tick(); expect_out(1'b0, 1'b1, "R5");
      wr(3'd5, 4'h8);

      // R8 impossible minute 75
      wr(3'd3, 4'h7); now_min_t = 3'd7; tick(); expect_out(1'b0, 1'b1, "R8");
      wr(3'd3, 4'h4); now_min_t = 3'd4;

      // R7 12-hour coding
      mode_24h = 1'b0;
      wr(3'd4, 4'h2); wr(3'd5, 4'h9);
      set_now(2'd1, 4'd2, 3'd4, 4'd5, 3'd2); tick(); expect_out(1'b1, 1'b0, "R7 AM 12");
      clr();
      now_hr_t = 2'd3; tick(); expect_out(1'b0, 1'b1, "R7 PM 12 vs AM 12");
      wr(3'd5, 4'hB); tick(); expect_out(1'b1, 1'b0, "R7 PM 12");
      clr();
      wr(3'd4, 4'h3); wr(3'd5, 4'h9);
      set_now(2'd1, 4'd3, 3'd4, 4'd5, 3'd2); tick(); expect_out(1'b0, 1'b1, "R7 hour 13 in 12h");
      mode_24h = 1'b1; tick(); expect_out(1'b1, 1'b0, "R7 hour 13 in 24h");
      clr();
      wr(3'd4, 4'h5); wr(3'd5, 4'hA);
      set_now(2'd2, 4'd5, 3'd4, 4'd5, 3'd2); tick(); expect_out(1'b0, 1'b1, "R7 hour 25");

      // R11 match coinciding with clear requests
      wr(3'd4, 4'h7); wr(3'd5, 4'h8);
      set_now(2'd0, 4'd7, 3'd4, 4'd5, 3'd2);
      min_tick = 1'b1; flag_clr = 1'b1; step(); min_tick = 1'b0; flag_clr = 1'b0;
      expect_out(1'b1, 1'b0, "R11 strobe");
      clr();
      min_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 4'h8;
      step(); min_tick = 1'b0; reg_wr = 1'b0;
      expect_out(1'b1, 1'b1, "R11 hold write");

      step();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule